// File: doc/BRIEF.md
# Cell Transmit Symbol Framer

The framer sits between a cell source and an external serial transmitter that understands command symbols. It takes fixed-length cells, one octet per clock, over a valid/ready handshake with a start-of-cell flag. It drives a 9-bit line port that carries one symbol per clock. When bit 8 is high, the symbol is a command and bits 7:0 hold its code. When bit 8 is low, bits 7:0 hold a cell data octet.

In symbol mode, every cell goes out as one sync command, one start-of-cell command, and then the cell's octets. When no cell is waiting, the port repeats the sync command. A receiver can lock onto the start-of-cell command and discard the sync fill.

Clearing the mode enable turns the block into a plain octet pipe with no command symbols. Changing the enable while a cell is in flight abandons that cell.

Top module: `cell_sym_framer`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `line_out` is the sync symbol 9'h101 (bit 8 set, code 8'h01). `cell_ready` is low when `sym_en` is high.
- R2: With `sym_en` high and no cell offered, `line_out` holds 9'h101 on every cycle. A command symbol (bit 8 high) only ever carries the sync code 8'h01 or the start-of-cell code 8'h02.
- R3: The symbol just before every cell's first data octet is the start-of-cell symbol 9'h102, and the symbol before that is 9'h101. When cells are offered back to back, exactly these two command symbols separate the last octet of one cell from the first octet of the next.
- R4: Each cell is sent as exactly 53 data symbols, in the order they were accepted, each with bit 8 low and the octet in bits 7:0.
- R5: In symbol mode, `cell_ready` is high only in data slots: 53 cycles per cell, plus one cycle for each mid-cell stall cycle.
- R6: If the beat offered in the first data slot lacks `cell_sof`, it is consumed and never appears on `line_out`. The block then sends the sync/start-of-cell preamble again before it accepts a first octet.
- R7: If `cell_valid` drops in a data slot after the first, the block sends 9'h101 for each such cycle, keeps its slot position, and resumes the cell with the next octet.
- R8: With `sym_en` low, `cell_ready` is high. The cycle after a beat is accepted, `line_out` is {1'b0, octet}. On cycles with no beat it is 9'h000.
- R9: Clearing `sym_en` in the middle of a cell abandons that cell. When `sym_en` is set again, the block starts in idle sync fill, and the next cell is sent complete from its first octet.
- R10: A synchronous active-high reset in the middle of a cell returns the block to idle sync fill. The next cell is sent complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | 1 = command-symbol mode, 0 = raw octet pipe |
| cell_valid | input | 1 | Source offers an octet |
| cell_sof | input | 1 | Offered octet is the first of a cell |
| cell_data | input | 8 | Offered octet |
| cell_ready | output | 1 | Block takes the offered octet on this edge |
| line_out | output | 9 | Line symbol: bit 8 command flag, bits 7:0 code or data |

## Verification
The hardest case to reach is a first data slot that is met by a beat without the start-of-cell flag. A well-behaved source never offers one, and the slot exists for only one cycle after the preamble. The stimulus sets this up by placing a marked junk octet without the flag at the head of the source queue. The source holds that octet through the preamble until the first data slot takes it. The bench then checks that the marker never reaches the line and that a second preamble comes before the real cell. A mid-cell stall is reached the same way: the source withholds valid for a set number of ready cycles at a chosen slot.

// File: rtl/sym_framer_pkg.sv
package sym_framer_pkg;

    // Sequencer phase in symbol mode
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // sync fill, also first preamble symbol
        ST_SOC  = 2'd1,   // start-of-cell symbol
        ST_DATA = 2'd2    // data slots
    } seq_state_t;

    // What the line register loads this cycle
    typedef enum logic [1:0] {
        SEL_SYNC = 2'd0,
        SEL_SOC  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_RAW  = 2'd3
    } line_sel_t;

endpackage

// File: rtl/sym_seq_ctrl.sv
module sym_seq_ctrl
    import sym_framer_pkg::*;
#(
    parameter int CELL_LEN = 53
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sym_en,
    input  logic      cell_valid,
    input  logic      cell_sof,
    output logic      cell_ready,
    output line_sel_t line_sel
);

    localparam int CNT_W = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(CELL_LEN - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        cell_ready = 1'b0;
        line_sel   = SEL_SYNC;
        if (!sym_en) begin
            r_d.st     = ST_IDLE;
            r_d.cnt    = '0;
            cell_ready = 1'b1;
            line_sel   = SEL_RAW;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (cell_valid) r_d.st = ST_SOC;
                end
                ST_SOC: begin
                    line_sel = SEL_SOC;
                    r_d.st   = ST_DATA;
                    r_d.cnt  = '0;
                end
                ST_DATA: begin
                    cell_ready = 1'b1;
                    if (r_q.cnt == '0 && !(cell_valid && cell_sof)) begin
                        // first slot must open a cell: drop and re-preamble
                        r_d.st = ST_IDLE;
                    end else if (cell_valid) begin
                        line_sel = SEL_DATA;
                        if (r_q.cnt == LAST_SLOT) begin
                            r_d.st  = ST_IDLE;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= LAST_SLOT);

    // R4
    cell_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_en && r_q.st == ST_DATA && r_q.cnt == LAST_SLOT && cell_valid)
        |=> (r_q.st == ST_IDLE && r_q.cnt == '0));

    // R5
    ready_window_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_en && cell_ready) |-> r_q.st == ST_DATA);

    // R6
    bad_sof_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_en && r_q.st == ST_DATA && r_q.cnt == '0 && cell_valid && !cell_sof)
        |=> r_q.st == ST_IDLE);

    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_en && r_q.st == ST_DATA && r_q.cnt != '0 && !cell_valid)
        |=> (r_q.st == ST_DATA && r_q.cnt == $past(r_q.cnt)));

endmodule

// File: rtl/sym_line_mux.sv
module sym_line_mux
    import sym_framer_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_CODE = DATA_W'(1),
    parameter logic [DATA_W-1:0] SOC_CODE  = DATA_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  line_sel_t         line_sel,
    input  logic              cell_valid,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W:0]   line_out
);

    localparam int              LINE_W   = DATA_W + 1;
    localparam logic [LINE_W-1:0] SYNC_SYM = {1'b1, SYNC_CODE};
    localparam logic [LINE_W-1:0] SOC_SYM  = {1'b1, SOC_CODE};

    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        case (line_sel)
            SEL_SOC:  line_d = SOC_SYM;
            SEL_DATA: line_d = {1'b0, cell_data};
            SEL_RAW:  line_d = cell_valid ? {1'b0, cell_data} : '0;
            default:  line_d = SYNC_SYM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= SYNC_SYM;
        else     line_q <= line_d;
    end

    assign line_out = line_q;

    // R2
    cmd_code_chk: assert property (@(posedge clk) disable iff (rst)
        line_q[DATA_W] |-> (line_q == SYNC_SYM || line_q == SOC_SYM));

    // R3
    soc_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (line_q == SOC_SYM) |-> $past(line_q) == SYNC_SYM);

endmodule

// File: rtl/cell_sym_framer.sv
module cell_sym_framer
    import sym_framer_pkg::*;
#(
    parameter int                CELL_LEN  = 53,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_CODE = DATA_W'(1),
    parameter logic [DATA_W-1:0] SOC_CODE  = DATA_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_en,
    input  logic              cell_valid,
    input  logic              cell_sof,
    input  logic [DATA_W-1:0] cell_data,
    output logic              cell_ready,
    output logic [DATA_W:0]   line_out
);

    line_sel_t line_sel;

    sym_seq_ctrl #(
        .CELL_LEN (CELL_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sym_en     (sym_en),
        .cell_valid (cell_valid),
        .cell_sof   (cell_sof),
        .cell_ready (cell_ready),
        .line_sel   (line_sel)
    );

    sym_line_mux #(
        .DATA_W    (DATA_W),
        .SYNC_CODE (SYNC_CODE),
        .SOC_CODE  (SOC_CODE)
    ) u_mux (
        .clk        (clk),
        .rst        (rst),
        .line_sel   (line_sel),
        .cell_valid (cell_valid),
        .cell_data  (cell_data),
        .line_out   (line_out)
    );

    // R8
    raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!sym_en) && $past(cell_valid))
        |-> line_out == {1'b0, $past(cell_data)});

endmodule

// File: tb/sim_cell_sym_framer.sv
module sim_cell_sym_framer;

    localparam int CLK_P    = 10;
    localparam int CELL_LEN = 53;
    localparam int CAP_MAX  = 512;
    localparam logic [8:0] SYM_SYNC = 9'h101;
    localparam logic [8:0] SYM_SOC  = 9'h102;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_en = 1'b1;
    logic       cell_valid = 1'b0;
    logic       cell_sof = 1'b0;
    logic [7:0] cell_data = 8'h00;
    logic       cell_ready;
    logic [8:0] line_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [8:0] cap [0:CAP_MAX-1];
    int cap_n = 0;
    bit cap_on = 1'b0;
    int rdy_n = 0;

    cell_sym_framer u0 (
        .clk        (clk),
        .rst        (rst),
        .sym_en     (sym_en),
        .cell_valid (cell_valid),
        .cell_sof   (cell_sof),
        .cell_data  (cell_data),
        .cell_ready (cell_ready),
        .line_out   (line_out)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (cap_on && cap_n < CAP_MAX) begin
            cap[cap_n] = line_out;
            cap_n++;
            if (cell_ready) rdy_n++;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] cap_at(input int idx);
        if (idx >= 0 && idx < cap_n) return cap[idx];
        return 9'h1FF;
    endfunction

    task automatic start_cap();
        @(negedge clk);
        cap_n  = 0;
        rdy_n  = 0;
        cap_on = 1'b1;
    endtask

    task automatic stop_cap();
        repeat (4) @(negedge clk);
        cap_on = 1'b0;
    endtask

    task automatic idle_src();
        @(negedge clk);
        cell_valid = 1'b0;
        cell_sof   = 1'b0;
    endtask

    // Source model: offers beats, honours ready, optional stall and junk head
    task automatic push_cell(input logic [7:0] base, input int gap_slot,
                             input int gap_len, input bit bad_first,
                             input int stop_after);
        int i = 0;
        int g = gap_len;
        bit junk = bad_first;
        while (i < stop_after) begin
            @(negedge clk);
            if (junk) begin
                cell_valid = 1'b1; cell_sof = 1'b0; cell_data = 8'hEE;
            end else if (i == gap_slot && g > 0) begin
                cell_valid = 1'b0; cell_sof = 1'b0;
            end else begin
                cell_valid = 1'b1; cell_sof = (i == 0); cell_data = base + 8'(i);
            end
            #1;
            if (cell_ready) begin
                if (junk) junk = 1'b0;
                else if (cell_valid) i++;
                else g--;
            end
        end
    endtask

    task automatic verify_cell(input logic [7:0] base, input int gap_slot,
                               input int gap_len, input int start_from,
                               output int end_idx);
        int k = -1;
        int j;
        for (int m = start_from + 1; m < cap_n - 1; m++)
            if (k < 0 && cap[m] == SYM_SOC && cap[m+1] == {1'b0, base}) k = m;
        if (k < 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3: start-of-cell before octet %h actual none expected one", base);
            end_idx = cap_n;
            return;
        end
        chk("R3", cap_at(k - 1), SYM_SYNC);
        j = k + 1;
        for (int i = 0; i < CELL_LEN; i++) begin
            if (i == gap_slot)
                for (int s = 0; s < gap_len; s++) begin
                    chk("R7", cap_at(j), SYM_SYNC);
                    j++;
                end
            chk("R4", cap_at(j), {1'b0, base + 8'(i)});
            j++;
        end
        chk("R2", cap_at(j), SYM_SYNC);
        end_idx = j;
    endtask

    function automatic int count_sym(input logic [8:0] sym);
        int n = 0;
        for (int m = 0; m < cap_n; m++) if (cap[m] == sym) n++;
        return n;
    endfunction

    task automatic t_reset();
        sym_en = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", line_out, SYM_SYNC);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", line_out, SYM_SYNC);
        chk("R1", {8'h0, cell_ready}, 9'h000);
    endtask

    task automatic t_idle();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R2", line_out, SYM_SYNC);
            chk("R5", {8'h0, cell_ready}, 9'h000);
        end
    endtask

    task automatic t_one_cell();
        int e;
        start_cap();
        push_cell(8'h10, -1, 0, 1'b0, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'h10, -1, 0, 0, e);
        chk_int("R3", count_sym(SYM_SOC), 1);
        chk_int("R5", rdy_n, CELL_LEN);
    endtask

    task automatic t_back2back();
        int e1;
        int e2;
        start_cap();
        push_cell(8'h20, -1, 0, 1'b0, CELL_LEN);
        push_cell(8'h60, -1, 0, 1'b0, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'h20, -1, 0, 0, e1);
        chk("R3", cap_at(e1 + 1), SYM_SOC);
        verify_cell(8'h60, -1, 0, e1, e2);
        chk_int("R3", count_sym(SYM_SOC), 2);
        chk_int("R5", rdy_n, 2 * CELL_LEN);
    endtask

    task automatic t_gap();
        int e;
        start_cap();
        push_cell(8'h40, 10, 3, 1'b0, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'h40, 10, 3, 0, e);
        chk_int("R7", rdy_n, CELL_LEN + 3);
    endtask

    task automatic t_bad_sof();
        int e;
        start_cap();
        push_cell(8'h00, -1, 0, 1'b1, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'h00, -1, 0, 0, e);
        chk_int("R6", count_sym(9'h0EE), 0);
        chk_int("R6", count_sym(SYM_SOC), 2);
    endtask

    task automatic t_raw();
        @(negedge clk);
        sym_en = 1'b0;
        #1;
        chk("R8", {8'h0, cell_ready}, 9'h001);
        @(negedge clk);
        chk("R8", line_out, 9'h000);
        cell_valid = 1'b1; cell_sof = 1'b0; cell_data = 8'hA5;
        @(negedge clk);
        chk("R8", line_out, 9'h0A5);
        cell_data = 8'h3C;
        @(negedge clk);
        chk("R8", line_out, 9'h03C);
        cell_valid = 1'b0;
        @(negedge clk);
        chk("R8", line_out, 9'h000);
        sym_en = 1'b1;
        @(negedge clk);
        chk("R9", line_out, SYM_SYNC);
    endtask

    task automatic t_abort();
        int e;
        push_cell(8'h70, -1, 0, 1'b0, 20);
        @(negedge clk);
        sym_en = 1'b0; cell_valid = 1'b0; cell_sof = 1'b0;
        @(negedge clk);
        chk("R9", line_out, 9'h000);
        sym_en = 1'b1;
        @(negedge clk);
        chk("R9", line_out, SYM_SYNC);
        chk("R9", {8'h0, cell_ready}, 9'h000);
        start_cap();
        push_cell(8'h80, -1, 0, 1'b0, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'h80, -1, 0, 0, e);
        chk_int("R9", rdy_n, CELL_LEN);
    endtask

    task automatic t_rst_mid();
        int e;
        push_cell(8'h90, -1, 0, 1'b0, 30);
        @(negedge clk);
        rst = 1'b1; cell_valid = 1'b0; cell_sof = 1'b0;
        @(negedge clk);
        chk("R10", line_out, SYM_SYNC);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", {8'h0, cell_ready}, 9'h000);
        start_cap();
        push_cell(8'hB0, -1, 0, 1'b0, CELL_LEN);
        idle_src();
        stop_cap();
        verify_cell(8'hB0, -1, 0, 0, e);
        chk_int("R10", rdy_n, CELL_LEN);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_one_cell();
        t_back2back();
        t_gap();
        t_bad_sof();
        t_raw();
        t_abort();
        t_rst_mid();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule